// File: doc/BRIEF.md
# FFT Peak-Interpolation Frequency Estimator

This block watches one 32-bin FFT frame arrive, one bin per accepted cycle, and refines the carrier frequency of the strongest tone to better than one bin. While the bins stream in, a running compare tracks the strongest bin. Bin strength is the L1 magnitude |re| + |im|. Every bin's strength and the absolute value of one chosen component are kept in small register arrays. At the end of the frame the block picks the stronger of the peak's two neighbours and forms the ratio a / (a + b). Here a is the chosen component of the neighbour and b is that of the peak. The ratio comes from a short restoring divider.

A single configuration bit picks whether the real or the imaginary part feeds the ratio. The result is the peak index plus a signed fraction in units of 1/128 bin, pointing toward the chosen neighbour. A one-cycle strobe marks it. A frame whose first bin arrives while the previous estimate is still being divided is discarded and reported on a separate pulse.

Top module: `fft_peak_interp`

## Requirements
- R1: While reset is low and in the first cycle after its release, est_valid, est_bin, est_frac, est_ok and frame_drop are all zero.
- R2: est_bin is the index (0 for the bin marked first, counting up per accepted bin) of the bin with the largest |re|+|im| in the frame; on equal strength the lowest index wins.
- R3: The interpolation neighbour is whichever of peak-1 and peak+1 has the larger |re|+|im|, the upper one on a tie, with index 0 and index 31 treated as adjacent.
- R4: With a and b the absolute chosen components of neighbour and peak, est_frac = min(floor(128*a/(a+b)), 127), negated when the neighbour is peak-1; est_ok is 1.
- R5: use_imag, sampled with the first bin of a frame, selects the component for the whole frame: 0 uses the real part, 1 the imaginary part.
- R6: If a+b is zero, est_frac is 0 and est_ok is 0.
- R7: est_valid is a one-cycle pulse, 9 clock edges after the edge that captures bin 31 when a+b is nonzero and 1 edge after when it is zero; est_bin, est_frac and est_ok hold their values until the next pulse.
- R8: An accepted bin with bin_first set in the middle of a frame restarts the search, and that bin becomes index 0.
- R9: A bin with bin_first set that arrives while an estimate is being computed produces a one-cycle frame_drop pulse on the next edge, and that frame yields no estimate. Bins without bin_first that arrive outside a frame are ignored.
- R10: Cycles with bin_valid low inside a frame are skipped, and the estimate is unchanged by such gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bin_valid | input | 1 | A bin is presented this cycle |
| bin_first | input | 1 | The presented bin is index 0 of a new frame |
| bin_re | input | 16 | Real part of the bin, two's complement |
| bin_im | input | 16 | Imaginary part of the bin, two's complement |
| use_imag | input | 1 | Component select, sampled with the first bin |
| est_valid | output | 1 | One-cycle estimate strobe |
| est_bin | output | 5 | Coarse peak index |
| est_frac | output | 8 | Signed offset toward the neighbour, 1/128 bin units |
| est_ok | output | 1 | 0 when both chosen components were zero |
| frame_drop | output | 1 | A frame was discarded because the divider was busy |

## Verification
The hardest case to reach is a new frame that starts inside the nine-cycle window while the divider runs. The stimulus reaches it by issuing a bin_first right after the last bin of a frame. It then streams the remaining 31 bins, which must be ignored, and follows with a clean frame to show the search recovers. Saturation at 127 is another case that is hard to reach. The bench builds frames where the peak is strong only in the component that is not chosen, so its chosen part is zero. Wrap-around cases put the peak at bin 0 or bin 31.

// File: rtl/fft_peak_interp.sv
module fft_peak_interp #(
  parameter int NPTS  = 32,
  parameter int DW    = 16,
  parameter int FRACW = 8,
  localparam int IDXW = $clog2(NPTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bin_valid,
  input  logic                    bin_first,
  input  logic signed [DW-1:0]    bin_re,
  input  logic signed [DW-1:0]    bin_im,
  input  logic                    use_imag,
  output logic                    est_valid,
  output logic [IDXW-1:0]         est_bin,
  output logic signed [FRACW-1:0] est_frac,
  output logic                    est_ok,
  output logic                    frame_drop
);
  localparam int MW   = DW + 1;
  localparam int RW   = DW + 2;
  localparam int SW   = (FRACW > 1) ? $clog2(FRACW) : 1;
  localparam int QMAX = (1 << (FRACW - 1)) - 1;

  typedef enum logic [1:0] {S_IDLE, S_PICK, S_DIV} state_t;

  state_t          state;
  logic [MW-1:0]   mag_mem [NPTS];
  logic [DW-1:0]   cmp_mem [NPTS];
  logic            collecting, sel_imag, neg;
  logic [IDXW-1:0] cnt, pk_idx;
  logic [MW-1:0]   pk_mag, den;
  logic [RW-1:0]   rem;
  logic [FRACW-1:0] quo;
  logic [SW-1:0]   step;

  logic [DW-1:0] re_abs, im_abs, in_cmp;
  logic [MW-1:0] in_mag;
  logic          cur_sel, busy, accept_first, accept_next, wr, last_bin, drop_ev;
  logic [IDXW-1:0] wr_idx;

  assign re_abs  = bin_re[DW-1] ? $unsigned(-bin_re) : $unsigned(bin_re);
  assign im_abs  = bin_im[DW-1] ? $unsigned(-bin_im) : $unsigned(bin_im);
  assign in_mag  = {1'b0, re_abs} + {1'b0, im_abs};
  assign cur_sel = bin_first ? use_imag : sel_imag;
  assign in_cmp  = cur_sel ? im_abs : re_abs;

  assign busy         = (state != S_IDLE);
  assign accept_first = bin_valid & bin_first & ~busy;
  assign accept_next  = bin_valid & ~bin_first & collecting;
  assign wr           = accept_first | accept_next;
  assign wr_idx       = accept_first ? '0 : cnt;
  assign last_bin     = wr && (wr_idx == IDXW'(NPTS - 1));
  assign drop_ev      = bin_valid & bin_first & busy;

  logic [IDXW-1:0] lo_idx, hi_idx, nb_idx;
  logic            take_hi;
  logic [DW-1:0]   nb_cmp, pk_cmp;
  logic [MW-1:0]   pair_sum;

  assign lo_idx   = (pk_idx == '0) ? IDXW'(NPTS - 1) : pk_idx - 1'b1;
  assign hi_idx   = (pk_idx == IDXW'(NPTS - 1)) ? '0 : pk_idx + 1'b1;
  assign take_hi  = mag_mem[hi_idx] >= mag_mem[lo_idx];
  assign nb_idx   = take_hi ? hi_idx : lo_idx;
  assign nb_cmp   = cmp_mem[nb_idx];
  assign pk_cmp   = cmp_mem[pk_idx];
  assign pair_sum = {1'b0, nb_cmp} + {1'b0, pk_cmp};

  logic             ge;
  logic [RW-1:0]    rem_sub;
  logic [FRACW-1:0] quo_n, sat_q;

  assign ge      = rem >= {1'b0, den};
  assign rem_sub = ge ? rem - {1'b0, den} : rem;
  assign quo_n   = {quo[FRACW-2:0], ge};
  assign sat_q   = (quo_n > FRACW'(QMAX)) ? FRACW'(QMAX) : quo_n;

  always_ff @(posedge clk) begin
    if (wr) begin
      mag_mem[wr_idx] <= in_mag;
      cmp_mem[wr_idx] <= in_cmp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      collecting <= 1'b0;
      sel_imag   <= 1'b0;
      cnt        <= '0;
      pk_idx     <= '0;
      pk_mag     <= '0;
    end else begin
      if (accept_first) begin
        sel_imag <= use_imag;
        pk_idx   <= '0;
        pk_mag   <= in_mag;
        cnt      <= IDXW'(1);
      end else if (accept_next) begin
        cnt <= cnt + 1'b1;
        if (in_mag > pk_mag) begin
          pk_idx <= cnt;
          pk_mag <= in_mag;
        end
      end
      if (last_bin)          collecting <= 1'b0;
      else if (accept_first) collecting <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      rem        <= '0;
      den        <= '0;
      quo        <= '0;
      step       <= '0;
      neg        <= 1'b0;
      est_valid  <= 1'b0;
      est_bin    <= '0;
      est_frac   <= '0;
      est_ok     <= 1'b0;
      frame_drop <= 1'b0;
    end else begin
      est_valid  <= 1'b0;
      frame_drop <= drop_ev;
      case (state)
        S_IDLE: if (last_bin) state <= S_PICK;
        S_PICK: begin
          neg <= ~take_hi;
          if (pair_sum == '0) begin
            est_valid <= 1'b1;
            est_bin   <= pk_idx;
            est_frac  <= '0;
            est_ok    <= 1'b0;
            state     <= S_IDLE;
          end else begin
            rem   <= {2'b00, nb_cmp};
            den   <= pair_sum;
            quo   <= '0;
            step  <= '0;
            state <= S_DIV;
          end
        end
        S_DIV: begin
          rem  <= {rem_sub[RW-2:0], 1'b0};
          quo  <= quo_n;
          step <= step + 1'b1;
          if (step == SW'(FRACW - 1)) begin
            est_valid <= 1'b1;
            est_bin   <= pk_idx;
            est_frac  <= neg ? -$signed(sat_q) : $signed(sat_q);
            est_ok    <= 1'b1;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |=> !est_valid); // R7
  AST_NO_EST_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    collecting |-> !est_valid); // R7
  AST_BAD_FRAC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (est_valid && !est_ok) |-> (est_frac == '0)); // R6
  AST_FRAC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |-> (est_frac <= QMAX && est_frac >= -QMAX)); // R4
  AST_DROP_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop |-> $past(state != S_IDLE)); // R9
  AST_DROP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop |=> !frame_drop || $past(drop_ev)); // R9
endmodule

// File: tb/fft_peak_interp_tb.sv
module fft_peak_interp_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bin_valid = 1'b0, bin_first = 1'b0, use_imag = 1'b0;
  logic signed [15:0] bin_re = '0, bin_im = '0;
  logic est_valid, est_ok, frame_drop;
  logic [4:0] est_bin;
  logic signed [7:0] est_frac;

  always #10 clk = ~clk;

  fft_peak_interp dut_i (
    .clk(clk), .rst_n(rst_n), .bin_valid(bin_valid), .bin_first(bin_first),
    .bin_re(bin_re), .bin_im(bin_im), .use_imag(use_imag),
    .est_valid(est_valid), .est_bin(est_bin), .est_frac(est_frac),
    .est_ok(est_ok), .frame_drop(frame_drop));

  int vectors = 0, miscompares = 0, cyc = 0;

  // behavioural reference
  int m_re[32], m_im[32];
  int m_sel, m_cnt, m_busy;
  bit m_coll, wb;
  bit e_valid, e_drop, e_ok, p_ok;
  int e_bin, e_frac, p_bin, p_frac;

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic compute();
    int mag[32];
    int pk, lo, hi, nb, a, b, q;
    for (int i = 0; i < 32; i++) mag[i] = iabs(m_re[i]) + iabs(m_im[i]);
    pk = 0;
    for (int i = 1; i < 32; i++) if (mag[i] > mag[pk]) pk = i;
    lo = (pk + 31) % 32;
    hi = (pk + 1) % 32;
    nb = (mag[hi] >= mag[lo]) ? hi : lo;
    a = m_sel ? iabs(m_im[nb]) : iabs(m_re[nb]);
    b = m_sel ? iabs(m_im[pk]) : iabs(m_re[pk]);
    p_bin = pk;
    if (a + b == 0) begin
      p_ok = 0; p_frac = 0;
    end else begin
      q = (a * 128) / (a + b);
      if (q > 127) q = 127;
      p_ok = 1;
      p_frac = (nb == lo) ? -q : q;
    end
  endtask

  task automatic store();
    m_re[m_cnt] = int'(bin_re);
    m_im[m_cnt] = int'(bin_im);
    m_cnt++;
    if (m_cnt == 32) begin
      m_coll = 0;
      compute();
      m_busy = p_ok ? 9 : 1;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_coll = 0; m_busy = 0; m_cnt = 0; m_sel = 0;
      e_valid = 0; e_drop = 0; e_ok = 0; e_bin = 0; e_frac = 0;
    end else begin
      wb = (m_busy > 0);
      e_valid = 0; e_drop = 0;
      if (m_busy > 0) begin
        m_busy--;
        if (m_busy == 0) begin
          e_valid = 1; e_bin = p_bin; e_frac = p_frac; e_ok = p_ok;
        end
      end
      if (bin_valid) begin
        if (bin_first) begin
          if (wb) begin e_drop = 1; m_coll = 0; end
          else begin m_coll = 1; m_cnt = 0; m_sel = int'(use_imag); store(); end
        end else if (m_coll) store();
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    vectors++;
    chk("R7", "est_valid", int'(est_valid), int'(e_valid));
    chk("R9", "frame_drop", int'(frame_drop), int'(e_drop));
    if (e_valid && est_valid) begin
      chk("R2", "est_bin", int'(est_bin), e_bin);
      chk("R4", "est_frac", int'(est_frac), e_frac);
      chk("R6", "est_ok", int'(est_ok), int'(e_ok));
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 100000) begin
    miscompares++;
    $display("FAIL watchdog: actual %0d expected below 100000", cyc);
    finish_run();
  end

  int f_re[32], f_im[32];

  task automatic noise(int seed);
    for (int i = 0; i < 32; i++) begin
      f_re[i] = ((i * 7 + seed) % 5) - 2;
      f_im[i] = ((i * 3 + seed) % 5) - 2;
    end
  endtask

  task automatic drive(bit first, int re, int im);
    @(negedge clk);
    bin_valid = 1'b1; bin_first = first;
    bin_re = 16'(re); bin_im = 16'(im);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bin_valid = 1'b0; bin_first = 1'b0;
    end
  endtask

  task automatic send(bit sel, bit gaps, int upto);
    use_imag = sel;
    for (int i = 0; i < upto; i++) begin
      drive(i == 0, f_re[i], f_im[i]);
      if (gaps && (i % 4 == 3)) idle(2);
    end
  endtask

  task automatic frame(bit sel, bit gaps);
    send(sel, gaps, 32);
    idle(14);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs cleared in reset
    chk("R1", "reset outputs", int'({est_valid, est_bin, est_frac, est_ok, frame_drop}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "after release", int'({est_valid, est_bin, est_frac, est_ok, frame_drop}), 0);

    // R2 R4: peak 10, upper neighbour stronger, real part
    noise(1); f_re[10] = 1000; f_re[11] = 600; f_re[9] = 200; frame(0, 0);
    // R5: imaginary part, lower neighbour, negative sign
    noise(2); f_im[5] = -3000; f_re[5] = 50; f_im[4] = 1500; f_re[4] = 9; f_re[6] = 400; frame(1, 0);
    // R5: same frame, real part selected
    frame(0, 0);
    // R3: wrap at 0 to 31
    noise(3); f_re[0] = 5000; f_re[31] = -2500; f_re[1] = 100; frame(0, 0);
    // R3: wrap at 31 to 0
    noise(4); f_re[31] = 4000; f_re[0] = 3000; f_re[30] = 10; frame(0, 0);
    // R3: tied neighbours take the upper one
    noise(0); f_re[12] = 2000; f_re[11] = 700; f_re[13] = -700; f_im[11] = 0; f_im[13] = 0; frame(0, 0);
    // R2: tied peaks keep the earliest
    noise(0); f_re[7] = 900; f_im[7] = 0; f_re[20] = 900; f_im[20] = 0; frame(0, 0);
    // R6: chosen components all zero
    for (int i = 0; i < 32; i++) begin f_re[i] = (i == 8) ? 800 : i; f_im[i] = 0; end
    frame(1, 0);
    // R4: saturation, peak strong only in the unchosen component
    noise(0); f_im[15] = 6000; f_re[15] = 0; f_re[16] = 900; f_re[14] = 3; frame(0, 0);
    // R10: gaps inside the frame
    noise(5); f_re[22] = -1200; f_re[23] = 300; f_re[21] = 800; frame(0, 1);
    // R8: restart in the middle of a frame
    noise(6); f_re[3] = 30000; send(0, 0, 10);
    noise(7); f_re[18] = 2200; f_re[19] = 1100; frame(0, 0);
    // R9: frame start while dividing, rest ignored, then recovery
    noise(8); f_re[26] = 1500; f_re[27] = 750; send(0, 0, 32);
    noise(9); f_re[2] = 20000; send(1, 0, 32);
    idle(14);
    // R9: stray bins outside a frame
    for (int i = 0; i < 8; i++) drive(0, 30000, 30000);
    idle(4);
    noise(10); f_re[9] = -32768; f_im[9] = -32768; f_re[8] = -32768; f_im[8] = 100; frame(0, 0);
    // R2 R4 R5: pseudo-random frames
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < 32; i++) begin
        f_re[i] = int'($urandom_range(0, 65535)) - 32768;
        f_im[i] = int'($urandom_range(0, 65535)) - 32768;
      end
      frame(n[0], n[2]);
    end
    idle(4);
    finish_run();
  end
endmodule